// File: doc/BRIEF.md
# Aligned divide-by-2/4/8 clock generator

This block turns one input clock into three slower clocks at one half, one quarter and one eighth of the input rate. All three are bits of a single 3-bit counter. That counter steps on the rising edge of an internally gated copy of the input clock, so every rising edge of a slower output falls on a rising edge of each faster one.

An active-low enable pauses and resumes the outputs. An active-high master reset clears them and lines the counter up with other copies of the block. Both controls reach the gate through one flop that is clocked on the falling input edge. The gated clock is therefore switched only while the input clock is low. A pause can never cut a high phase short, and a resume continues the count where it stopped. Synchronous pause and restart of related clock domains is the intended use.

Top module: `clkdiv_248`

## Requirements
- R1: `q_div2`, `q_div4` and `q_div8` are bits 0, 1 and 2 of the counter. While running freely they make 32, 16 and 8 rising edges in every 64 input cycles.
- R2: All three outputs rise together on one input edge once every eight counting edges (count 0 to 7). Any rising edge of `q_div8` finds `q_div4` and `q_div2` high.
- R3: The counter steps down by one, modulo 8, on each rising input edge for which the falling-edge run flop holds 1. In every other case it keeps its value.
- R4: At each falling input edge the run flop loads (`en_n` low and `mreset` low). A pause therefore takes effect at the first falling edge after `en_n` goes high, and a resume at the first falling edge after it returns low. The count resumes from the held value. An `en_n` pulse that does not span a falling edge has no effect.
- R5: While `mreset` is high, all outputs are 0 and the run flop is cleared, whatever the clock and the enable do.
- R6: If `mreset` is released while the input clock is high, the outputs read 3'b111 after the first following rising edge.
- R7: If `mreset` is released while the input clock is low, the outputs stay 0 across the first following rising edge and read 3'b111 after the second.
- R8: Outside reset, an output changes only while the input clock is high, and no output pulse lasts less than one input period.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_in | input | 1 | Input clock |
| en_n | input | 1 | Active-low run enable, sampled on falling edge |
| mreset | input | 1 | Active-high master reset, asynchronous clear |
| q_div2 | output | 1 | Input clock divided by 2 |
| q_div4 | output | 1 | Input clock divided by 4 |
| q_div8 | output | 1 | Input clock divided by 8 |

## Verification
The hardest cases hinge on where, within one input period, a control input changes. Three of them matter: an enable change just before or after a falling edge, an enable pulse that ends before any falling edge, and a reset release in either clock phase. The stimulus places each control change a fixed 2 ns after a chosen clock edge, so every case is reached deliberately. A pulse-width monitor watches each output change for timing relative to the input clock, which exposes any gating done outside the low phase.

// File: rtl/clkdiv_pkg.sv
// Shared width and count type for the divide-by-2/4/8 generator.
package clkdiv_pkg;
    localparam int DIV_STAGES = 3;
    typedef logic [DIV_STAGES-1:0] div_count_t;
endpackage

// File: rtl/clkdiv_run_capture.sv
// Falling-edge run flop. Loads (enable active and reset inactive) on each
// falling input edge; reset clears it at once. Assumes controls settle
// away from the falling edge.
module clkdiv_run_capture (
    input  logic clk_in,
    input  logic en_n,
    input  logic mreset,
    output logic run_q
);
    // Capture run permission while the input clock goes low (R4, R5).
    always_ff @(negedge clk_in or posedge mreset) begin
        if (mreset) run_q <= 1'b0;
        else        run_q <= ~en_n;
    end
endmodule

// File: rtl/clkdiv_gate.sv
// Clock gate. Passes the input clock while run is set. Assumes run
// changes only while the input clock is low, so no pulse is ever trimmed.
module clkdiv_gate (
    input  logic clk_in,
    input  logic run_q,
    output logic gclk
);
    // AND gate; safe because run_q only moves on the falling edge (R8).
    assign gclk = clk_in & run_q;
endmodule

// File: rtl/clkdiv_counter.sv
// Down counter on the gated clock with asynchronous clear. Counting down
// makes all bits rise together on the wrap from 0 to all ones.
module clkdiv_counter #(
    parameter int WIDTH = 3
) (
    input  logic             gclk,
    input  logic             mreset,
    output logic [WIDTH-1:0] count
);
    localparam logic [WIDTH-1:0] STEP = {{(WIDTH-1){1'b0}}, 1'b1};

    // Step down on each gated edge; clear while reset is high (R3, R5).
    always_ff @(posedge gclk or posedge mreset) begin
        if (mreset) count <= '0;
        else        count <= count - STEP;
    end
endmodule

// File: rtl/clkdiv_248.sv
// Top of the divide-by-2/4/8 generator: falling-edge run capture, clock
// gate and shared counter. Each output is one counter bit (R1, R2).
module clkdiv_248
    import clkdiv_pkg::*;
(
    input  logic clk_in,
    input  logic en_n,
    input  logic mreset,
    output logic q_div2,
    output logic q_div4,
    output logic q_div8
);
    logic       run_q;
    logic       gclk;
    div_count_t count;
    logic [DIV_STAGES-1:0] q_bus;

    clkdiv_run_capture u_run (
        .clk_in (clk_in),
        .en_n   (en_n),
        .mreset (mreset),
        .run_q  (run_q)
    );

    clkdiv_gate u_gate (
        .clk_in (clk_in),
        .run_q  (run_q),
        .gclk   (gclk)
    );

    clkdiv_counter #(.WIDTH(DIV_STAGES)) u_cnt (
        .gclk   (gclk),
        .mreset (mreset),
        .count  (count)
    );

    // Each output stage taps its own counter bit.
    for (genvar i = 0; i < DIV_STAGES; i++) begin : g_tap
        assign q_bus[i] = count[i];
    end

    assign q_div2 = q_bus[0];
    assign q_div4 = q_bus[1];
    assign q_div8 = q_bus[2];
endmodule

// File: rtl/clkdiv_248_checker.sv
// Assertion checker for clkdiv_248, bound to every instance.
module clkdiv_248_checker (
    input logic       clk_in,
    input logic       en_n,
    input logic       mreset,
    input logic       run_q,
    input logic [2:0] count
);
    // R3: a running edge steps the count down by one
    a_r3_step: assert property (@(posedge clk_in) disable iff (mreset)
        run_q |=> (count == $past(count) - 3'd1));

    // R3: a gated edge leaves the count alone
    a_r3_hold: assert property (@(posedge clk_in) disable iff (mreset)
        !run_q |=> (count == $past(count)));

    // R4: run flop follows the enable sampled at the falling edge
    a_r4_run_on: assert property (@(negedge clk_in) disable iff (mreset)
        !en_n |=> run_q);
    a_r4_run_off: assert property (@(negedge clk_in) disable iff (mreset)
        en_n |=> !run_q);

    // R5: reset holds counter and run flop clear
    a_r5_clear: assert property (@(posedge clk_in)
        mreset |-> (count == 3'd0 && !run_q));

    // R2: a rising slowest output finds the faster ones high
    a_r2_aligned: assert property (@(posedge clk_in) disable iff (mreset)
        $rose(count[2]) |-> (count[1] && count[0]));
endmodule

bind clkdiv_248 clkdiv_248_checker u_chk (
    .clk_in (clk_in),
    .en_n   (en_n),
    .mreset (mreset),
    .run_q  (run_q),
    .count  (count)
);

// File: tb/clkdiv_248_test.sv
`timescale 1ns/1ps
module clkdiv_248_test;
    logic clk = 1'b0;
    logic en_n = 1'b0;
    logic mreset = 1'b0;
    logic q_div2, q_div4, q_div8;

    int checks = 0;
    int errors = 0;

    clkdiv_248 uut (
        .clk_in (clk),
        .en_n   (en_n),
        .mreset (mreset),
        .q_div2 (q_div2),
        .q_div4 (q_div4),
        .q_div8 (q_div8)
    );

    always #5 clk = ~clk;

    // Behavioural reference model
    int  m_cnt = 0;
    bit  m_run = 0;
    always @(negedge clk) m_run = (!en_n && !mreset);
    always @(posedge clk) if (m_run && !mreset) m_cnt = (m_cnt + 7) % 8;
    always @(posedge mreset) begin m_cnt = 0; m_run = 0; end

    function automatic int outs();
        return {29'd0, q_div8, q_div4, q_div2};
    endfunction

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model (R3), plus wrap counter (R2)
    int prev_out = 0;
    int triple = 0;
    always @(posedge clk) begin
        #2;
        check("R3 model compare", outs(), m_cnt);
        if (prev_out == 0 && outs() == 7) triple++;
        prev_out = outs();
    end

    // Rising-edge counters for division ratios (R1)
    int r2 = 0, r4 = 0, r8 = 0;
    always @(posedge q_div2) r2++;
    always @(posedge q_div4) r4++;
    always @(posedge q_div8) r8++;

    // Pulse monitor (R8)
    int viol = 0;
    real last_t = -1.0;
    always @(posedge mreset) last_t = -1.0;
    always @(q_div2 or q_div4 or q_div8) begin
        if (!mreset && $time > 0) begin
            if (clk !== 1'b1) viol++;
            if (last_t >= 0.0 && ($realtime - last_t) < 9.5) viol++;
            last_t = $realtime;
        end
    end

    task automatic at_high(); @(posedge clk); #2; endtask
    task automatic at_low();  @(negedge clk); #2; endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        int v;
        #1 mreset = 1'b1;
        repeat (3) at_high();
        check("R5 reset outputs low", outs(), 0);
        en_n = 1'b1;
        at_low();
        check("R5 reset ignores enable", outs(), 0);
        en_n = 1'b0;

        // R6: release in the high phase
        at_high();
        mreset = 1'b0;
        at_high();
        check("R6 first edge after high release", outs(), 7);
        check("R2 all outputs rise together", outs(), 7);

        // R1 / R2: free-running window
        r2 = 0; r4 = 0; r8 = 0; triple = 0;
        repeat (64) at_high();
        check("R1 div2 rises", r2, 32);
        check("R1 div4 rises", r4, 16);
        check("R1 div8 rises", r8, 8);
        check("R2 common rise every eighth edge", triple, 8);

        // R4: pause set in low phase -> one more step, then frozen
        at_low();
        en_n = 1'b1;
        at_high();
        v = outs();
        repeat (4) at_high();
        check("R4 frozen after low-phase pause", outs(), v);
        // resume in high phase -> continues from held count
        en_n = 1'b0;
        at_high();
        check("R4 resume continues count", outs(), (v + 7) % 8);

        // R4: pause set in high phase -> no step on next edge
        v = outs();
        en_n = 1'b1;
        at_high();
        check("R4 high-phase pause holds", outs(), v);
        repeat (3) at_high();
        en_n = 1'b0;
        at_high();
        check("R4 resume after high-phase pause", outs(), (v + 7) % 8);

        // R4: pulse not spanning a falling edge is ignored
        v = outs();
        en_n = 1'b1;
        #1 en_n = 1'b0;
        at_high();
        check("R4 short pulse ignored", outs(), (v + 7) % 8);

        // R7: release in the low phase
        at_high();
        mreset = 1'b1;
        repeat (2) at_high();
        at_low();
        mreset = 1'b0;
        at_high();
        check("R7 first edge after low release", outs(), 0);
        at_high();
        check("R7 second edge after low release", outs(), 7);

        repeat (20) at_high();
        check("R8 no early change or short pulse", viol, 0);
        summary();
    end
endmodule